// File: doc/BRIEF.md
# Privilege Level Entry and Return Controller

This block tracks which of four privilege levels (0 least privileged, 3 most) the processor is running at and performs the level change for exception entry and exception return. When an exception is taken to a higher level, the block records two values in registers that belong only to the target level: the interrupted processor state word, with the old level written into it, and the return address. It then issues a one-cycle new-PC strobe carrying that level's vector address.

An exception-return request reads back the pair banked for the current level. It restores the saved state word, takes the new level from that word and redirects fetch to the saved return address. Level 0 has no banked storage. The block also carries a narrow/wide execution-width flag, and that flag can change only at an entry or a return. Requests that would not raise the level, and returns attempted at level 0, change nothing and raise a one-cycle error pulse.

Top module: `exlvl_ctrl`

## Requirements
- R1: After reset, `cur_lvl` is 0, `npc_vld` is 0, `err` is 0 and `narrow` is 0.
- R2: An exception request whose target is above the current level is accepted, and `cur_lvl` equals the target one clock after the request is sampled.
- R3: On an accepted entry, `npc_vld` is high for one cycle in the cycle after the request, with `npc = VEC_BASE + target*VEC_STRIDE + VEC_OFS`. `npc_vld` is high only after an accepted entry or return.
- R4: An accepted entry stores `ret_pc`, and `cur_state` with bits 3:2 replaced by the level being left, into the target level's bank. A later return from that level presents these as `npc` and `rest_state`.
- R5: An accepted return (`ret_req` high, no exception request, level not 0) sets `cur_lvl` to bits 3:2 of the restored state word and pulses `npc_vld` for one cycle.
- R6: An exception request whose target is at or below the current level is ignored. `cur_lvl`, `narrow` and the banks keep their values, `npc_vld` stays low, and `err` pulses for one cycle.
- R7: A return request at level 0 leaves all state unchanged, keeps `npc_vld` low and pulses `err` for one cycle.
- R8: When an exception request and a return request come in the same cycle, the exception request is handled and the return request is dropped.
- R9: `narrow` becomes 0 on an accepted entry and becomes bit 4 of the restored state word on an accepted return. It does not change at any other time, whatever `cur_state` does.
- R10: Banks are kept per level, so nested entries 0→1→2→3 followed by three returns restore levels 2, 1, 0 and each level's own return address.
- R11: `npc_vld` and `err` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_req | input | 1 | Exception request |
| exc_tgt | input | 2 | Target level of the request |
| ret_req | input | 1 | Exception-return request |
| cur_state | input | SW | Processor state word of the running code |
| ret_pc | input | PC_W | Return address to bank on entry |
| cur_lvl | output | 2 | Current privilege level |
| narrow | output | 1 | Execution-width flag (1 = narrow) |
| npc_vld | output | 1 | One-cycle new-PC strobe |
| npc | output | PC_W | New fetch address |
| rest_state | output | SW | State word restored by the last return |
| err | output | 1 | One-cycle illegal-request pulse |

## Verification
The hardest case to reach is a return from the top of a deep nest in which every bank holds a different saved pair and the saved width bits differ between levels. Only that case shows that the read mux, the bank write enables and the level field are wired correctly, and not merely consistent for a single level. To reach it, the bench climbs through every reachable starting level and then tries every target from there. After each attempt it unwinds to level 0 with returns. It also builds one full 0→1→2→3 nest with a distinct state word, width bit and return address at each step. A reference model in the bench predicts the level, vector, restored word and width after each step.

// File: rtl/exlvl_pkg.sv
package exlvl_pkg;
  localparam int NLVL    = 4;
  localparam int LVL_W   = $clog2(NLVL);
  localparam int LVL_LSB = 2;   // previous level field in state word
  localparam int NAR_BIT = 4;   // execution width bit in state word
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/exlvl_bank.sv
module exlvl_bank #(
  parameter int PC_W = 64,
  parameter int SW   = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [SW-1:0]   wr_state,
  input  logic [PC_W-1:0] wr_pc,
  output logic [SW-1:0]   state_q,
  output logic [PC_W-1:0] pc_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= '0;
      pc_q    <= '0;
    end else if (wr_en) begin
      state_q <= wr_state;
      pc_q    <= wr_pc;
    end
  end

  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(state_q) && $stable(pc_q))); // R4
endmodule

// File: rtl/exlvl_vec.sv
module exlvl_vec
  import exlvl_pkg::*;
#(
  parameter int              PC_W       = 64,
  parameter logic [PC_W-1:0] VEC_BASE   = '0,
  parameter logic [PC_W-1:0] VEC_STRIDE = '0,
  parameter logic [PC_W-1:0] VEC_OFS    = '0
) (
  input  lvl_t            tgt,
  output logic [PC_W-1:0] vec
);
  logic [PC_W-1:0] tgt_ext;
  always_comb begin
    tgt_ext = '0;
    tgt_ext[LVL_W-1:0] = tgt;
    vec = VEC_BASE + tgt_ext * VEC_STRIDE + VEC_OFS;
  end
endmodule

// File: rtl/exlvl_core.sv
module exlvl_core
  import exlvl_pkg::*;
#(
  parameter int PC_W = 64,
  parameter int SW   = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            exc_req,
  input  lvl_t            exc_tgt,
  input  logic            ret_req,
  input  logic [PC_W-1:0] vec,
  input  logic [SW-1:0]   rd_state,
  input  logic [PC_W-1:0] rd_pc,
  output logic            take_exc,
  output lvl_t            lvl_q,
  output logic            narrow_q,
  output logic            npc_vld_q,
  output logic [PC_W-1:0] npc_q,
  output logic [SW-1:0]   rest_q,
  output logic            err_q
);
  logic bad_exc, take_ret, bad_ret;

  always_comb begin
    take_exc = exc_req && (exc_tgt > lvl_q);
    bad_exc  = exc_req && !(exc_tgt > lvl_q);
    take_ret = ret_req && !exc_req && (lvl_q != '0);
    bad_ret  = ret_req && !exc_req && (lvl_q == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q     <= '0;
      narrow_q  <= 1'b0;
      npc_vld_q <= 1'b0;
      npc_q     <= '0;
      rest_q    <= '0;
      err_q     <= 1'b0;
    end else begin
      npc_vld_q <= take_exc || take_ret;
      err_q     <= bad_exc || bad_ret;
      if (take_exc) begin
        lvl_q    <= exc_tgt;
        npc_q    <= vec;
        narrow_q <= 1'b0;
      end else if (take_ret) begin
        lvl_q    <= rd_state[LVL_LSB +: LVL_W];
        npc_q    <= rd_pc;
        rest_q   <= rd_state;
        narrow_q <= rd_state[NAR_BIT];
      end
    end
  end

  AST_RAISE: assert property (@(posedge clk) disable iff (rst)
    (exc_req && exc_tgt > lvl_q) |=> (lvl_q == $past(exc_tgt) && npc_vld_q)); // R2
  AST_NPC_CAUSE: assert property (@(posedge clk) disable iff (rst)
    npc_vld_q |-> $past(exc_req || ret_req)); // R3
  AST_IGNORE_LOW: assert property (@(posedge clk) disable iff (rst)
    (exc_req && exc_tgt <= lvl_q) |=> ($stable(lvl_q) && err_q && !npc_vld_q)); // R6
  AST_RET_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (ret_req && !exc_req && lvl_q == '0) |=> (lvl_q == '0 && err_q && !npc_vld_q)); // R7
  AST_WIDTH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!exc_req && !ret_req) |=> $stable(narrow_q)); // R9
  AST_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(npc_vld_q && err_q)); // R11
endmodule

// File: rtl/exlvl_ctrl.sv
module exlvl_ctrl
  import exlvl_pkg::*;
#(
  parameter int              PC_W       = 64,
  parameter int              SW         = 32,
  parameter logic [PC_W-1:0] VEC_BASE   = 64'h0000_0000_4000_0000,
  parameter logic [PC_W-1:0] VEC_STRIDE = 64'h0000_0000_0000_1000,
  parameter logic [PC_W-1:0] VEC_OFS    = 64'h0000_0000_0000_0400
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            exc_req,
  input  logic [1:0]      exc_tgt,
  input  logic            ret_req,
  input  logic [SW-1:0]   cur_state,
  input  logic [PC_W-1:0] ret_pc,
  output logic [1:0]      cur_lvl,
  output logic            narrow,
  output logic            npc_vld,
  output logic [PC_W-1:0] npc,
  output logic [SW-1:0]   rest_state,
  output logic            err
);
  logic [SW-1:0]   bk_state [NLVL];
  logic [PC_W-1:0] bk_pc    [NLVL];
  logic [SW-1:0]   save_word;
  logic [PC_W-1:0] vec;
  logic            take_exc;
  lvl_t            lvl_q;

  // state word to bank: running word with the departing level inserted
  always_comb begin
    save_word = cur_state;
    save_word[LVL_LSB +: LVL_W] = lvl_q;
  end

  // level 0 owns no bank; its slot reads as zero
  assign bk_state[0] = '0;
  assign bk_pc[0]    = '0;

  for (genvar g = 1; g < NLVL; g++) begin : g_bank
    exlvl_bank #(.PC_W(PC_W), .SW(SW)) u_bank (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (take_exc && (exc_tgt == lvl_t'(g))),
      .wr_state (save_word),
      .wr_pc    (ret_pc),
      .state_q  (bk_state[g]),
      .pc_q     (bk_pc[g])
    );
  end

  exlvl_vec #(
    .PC_W(PC_W), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE), .VEC_OFS(VEC_OFS)
  ) u_vec (
    .tgt (exc_tgt),
    .vec (vec)
  );

  exlvl_core #(.PC_W(PC_W), .SW(SW)) u_core (
    .clk       (clk),
    .rst       (rst),
    .exc_req   (exc_req),
    .exc_tgt   (exc_tgt),
    .ret_req   (ret_req),
    .vec       (vec),
    .rd_state  (bk_state[lvl_q]),
    .rd_pc     (bk_pc[lvl_q]),
    .take_exc  (take_exc),
    .lvl_q     (lvl_q),
    .narrow_q  (narrow),
    .npc_vld_q (npc_vld),
    .npc_q     (npc),
    .rest_q    (rest_state),
    .err_q     (err)
  );

  assign cur_lvl = lvl_q;

  initial begin
    AST_SW_WIDE: assert (SW > NAR_BIT); // R9
  end
endmodule

// File: tb/sim_exlvl_ctrl.sv
module sim_exlvl_ctrl;
  localparam int PC_W = 64;
  localparam int SW   = 32;
  localparam logic [PC_W-1:0] VB = 64'h0000_0000_4000_0000;
  localparam logic [PC_W-1:0] VS = 64'h0000_0000_0000_1000;
  localparam logic [PC_W-1:0] VO = 64'h0000_0000_0000_0400;

  logic clk = 0, rst = 1;
  logic exc_req = 0, ret_req = 0;
  logic [1:0] exc_tgt = 0;
  logic [SW-1:0] cur_state = 0;
  logic [PC_W-1:0] ret_pc = 0;
  logic [1:0] cur_lvl;
  logic narrow, npc_vld, err;
  logic [PC_W-1:0] npc;
  logic [SW-1:0] rest_state;

  int nchk = 0, nfail = 0;
  bit done = 0;

  // reference model
  int m_lvl;
  bit m_nar;
  logic [SW-1:0]   m_bs [4];
  logic [PC_W-1:0] m_bp [4];
  logic [SW-1:0]   m_rest;

  always #10 clk = ~clk;

  exlvl_ctrl #(.PC_W(PC_W), .SW(SW), .VEC_BASE(VB), .VEC_STRIDE(VS), .VEC_OFS(VO)) u0 (
    .clk(clk), .rst(rst), .exc_req(exc_req), .exc_tgt(exc_tgt), .ret_req(ret_req),
    .cur_state(cur_state), .ret_pc(ret_pc), .cur_lvl(cur_lvl), .narrow(narrow),
    .npc_vld(npc_vld), .npc(npc), .rest_state(rest_state), .err(err));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1; exc_req = 0; ret_req = 0;
    @(negedge clk); @(negedge clk);
    rst = 0;
    m_lvl = 0; m_nar = 0; m_rest = '0;
    chk(cur_lvl == 0, "R1 level", 64'(cur_lvl), 0);
    chk(!npc_vld && !err, "R1 strobes", {62'b0, npc_vld, err}, 0);
    chk(!narrow, "R1 width", 64'(narrow), 0);
  endtask

  // drive one request cycle, then check every output against the model
  task automatic step(input bit e, input int t, input bit r,
                      input logic [SW-1:0] st, input logic [PC_W-1:0] pc);
    bit acc, bad_e, accr, badr;
    logic [PC_W-1:0] e_npc;
    logic [SW-1:0] sv;
    string ltag;
    e_npc = npc;
    acc   = e && (t > m_lvl);
    bad_e = e && !acc;
    accr  = r && !e && (m_lvl != 0);
    badr  = r && !e && (m_lvl == 0);
    exc_req = e; exc_tgt = 2'(t); ret_req = r; cur_state = st; ret_pc = pc;
    @(negedge clk);
    exc_req = 0; ret_req = 0;
    if (acc) begin
      sv = st; sv[3:2] = 2'(m_lvl);
      m_bs[t] = sv; m_bp[t] = pc;
      m_lvl = t; m_nar = 0;
      e_npc = VB + PC_W'(t) * VS + VO;
      ltag = "R2 level";
    end else if (accr) begin
      m_rest = m_bs[m_lvl];
      e_npc = m_bp[m_lvl];
      m_nar = m_rest[4];
      m_lvl = int'(m_rest[3:2]);
      ltag = "R5 level";
    end else if (bad_e) ltag = "R6 level";
    else if (badr) ltag = "R7 level";
    else ltag = "R9 idle level";
    chk(cur_lvl == 2'(m_lvl), ltag, 64'(cur_lvl), 64'(m_lvl));
    chk(npc_vld == (acc || accr), "R3 strobe", 64'(npc_vld), 64'(acc || accr));
    chk(err == (bad_e || badr), bad_e ? "R6 err" : "R7 err", 64'(err), 64'(bad_e || badr));
    chk(narrow == m_nar, "R9 width", 64'(narrow), 64'(m_nar));
    if (acc || accr)
      chk(npc == e_npc, acc ? "R3 vector" : "R4 return pc", npc, e_npc);
    if (accr)
      chk(rest_state == m_rest, "R4 restored state", 64'(rest_state), 64'(m_rest));
    chk(!(npc_vld && err), "R11 exclusive", {62'b0, npc_vld, err}, 0);
  endtask

  task automatic idle(input logic [SW-1:0] st);
    step(0, 0, 0, st, '0);
  endtask

  initial begin
    do_reset();
    // sweep: every starting level against every target
    for (int l = 0; l < 4; l++) begin
      for (int t = 0; t < 4; t++) begin
        do_reset();
        if (l > 0) step(1, l, 0, 32'h1357_0010 ^ (l << 8), 64'h8000_0000_0000_0000 + l * 64'h40);
        step(1, t, 0, 32'hA5A5_0000 ^ 32'((l * 4 + t) << 4), 64'h1234_0000 + 64'(l * 16 + t) * 4);
        idle(32'hFFFF_FFFF);
        while (m_lvl != 0) step(0, 0, 1, 0, 0);
        step(0, 0, 1, 0, 0);   // R7: return at level 0
      end
    end
    // R10: full nest with distinct words and width bits
    do_reset();
    step(1, 1, 0, 32'h0000_0010, 64'hAAAA_0000);
    step(1, 2, 0, 32'h0000_0F00, 64'hBBBB_0000);
    step(1, 3, 0, 32'h0000_0013, 64'hCCCC_0000);
    step(0, 0, 1, 0, 0);
    chk(cur_lvl == 2 && npc == 64'hCCCC_0000, "R10 unwind to 2", {cur_lvl, npc[61:0]}, {2'd2, 62'hCCCC_0000});
    step(0, 0, 1, 0, 0);
    chk(cur_lvl == 1 && npc == 64'hBBBB_0000, "R10 unwind to 1", {cur_lvl, npc[61:0]}, {2'd1, 62'hBBBB_0000});
    step(0, 0, 1, 0, 0);
    chk(cur_lvl == 0 && narrow, "R10 unwind to 0", {62'b0, cur_lvl == 0, narrow}, 3);
    // R9: width flag ignores cur_state changes while idle
    for (int k = 0; k < 4; k++) idle(32'(k) << 4);
    chk(narrow == 1'b1, "R9 hold", 64'(narrow), 1);
    // R8: simultaneous requests, entry wins
    step(1, 1, 0, 32'h10, 64'h100);
    step(1, 2, 1, 32'h20, 64'h200);
    chk(cur_lvl == 2, "R8 entry wins", 64'(cur_lvl), 2);
    step(1, 3, 0, 32'h30, 64'h300);
    step(1, 1, 1, 32'h40, 64'h400);   // bad entry + return: return dropped
    chk(cur_lvl == 3 && err, "R8 return dropped", {62'b0, cur_lvl == 3, err}, 3);
    // skip levels: 0 -> 3 directly then back
    do_reset();
    step(1, 3, 0, 32'h0000_00F0, 64'hDEAD_BEE0);
    step(0, 0, 1, 0, 0);
    chk(cur_lvl == 0 && npc == 64'hDEAD_BEE0, "R5 skip return", {cur_lvl, npc[61:0]}, {2'd0, 62'hDEAD_BEE0});
    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule